// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

The block turns one parallel byte into one asynchronous serial frame on a single output line. A frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one, one and a half or two high stop bits. All timing comes from a baud tick input that pulses once per clock at sixteen times the bit rate, so every bit lasts 16 ticks.

A host places a byte on `data`, sets the line-control inputs and pulses `load` while `busy` is low. The block captures the byte and every line-control setting in that cycle, so the host may change them during the frame. `busy` stays high until the last stop tick has passed. A separate break input forces the line low at any time without disturbing the serializer, which keeps counting through its frame.

Top module: `uart_tx_frame`

## Requirements
- R1: `wlen` selects the data length (00=5, 01=6, 10=7, 11=8 bits). Data bits go out least significant bit first, each 16 ticks long, starting right after the start bit.
- R2: The line idles at 1. A frame starts with a 0 lasting 16 ticks, counted from the first tick after the accepted load.
- R3: With `stop_sel`=0 the frame ends with a single 1 lasting 16 ticks, for every word length.
- R4: With `stop_sel`=1 the stop period is 1 for 24 ticks when the word is 5 bits, and 1 for 32 ticks when the word is 6, 7 or 8 bits.
- R5: With `par_en`=1 a parity bit of 16 ticks follows the last data bit. `par_even`=0 gives an odd count of ones over the data and parity bits, and `par_even`=1 gives an even count.
- R6: With `par_en`=1 and `par_stick`=1 the parity bit is the constant inverse of `par_even`.
- R7: While `brk`=1, `txd` is 0 whatever the serializer state. Frame timing and `busy` are unaffected. When `brk` returns to 0, `txd` again follows the serializer.
- R8: A load is accepted only while `busy`=0, and `busy` is 1 from the next cycle. Loads while busy are ignored. The byte and the line-control settings are taken only at acceptance.
- R9: `busy` changes only on a tick. It falls on the tick that ends the stop period, with `txd` at 1 just before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Baud tick, one pulse per 1/16 bit time |
| load | input | 1 | Start a frame with `data` |
| data | input | 8 | Byte to send |
| wlen | input | 2 | Word length code |
| stop_sel | input | 1 | Long stop period select |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Constant parity select |
| brk | input | 1 | Force line low |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
The assertions check, on every cycle, the properties that hold at the edges of a frame. Break holds the line low. The idle line is high. An accepted load raises `busy` with the line low. `busy` only falls on a tick and after a high stop bit. The bit order, the parity value for each mode, the stop length for each word length, and the rule that mid-frame loads and setting changes are ignored depend on the whole frame. Only the bench's scenarios show these: it samples each bit at mid-period and counts ticks until `busy` falls.

// File: rtl/uart_tx_frame.sv
module uart_tx_frame #(
  parameter int TPB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] data,
  input  logic [1:0] wlen,
  input  logic       stop_sel,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       brk,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(2 * TPB);

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP} st_t;
  st_t st;

  logic [7:0]    sh;
  logic [2:0]    idx;
  logic [CW-1:0] tcnt, lim;
  logic [1:0]    c_wlen;
  logic          c_stop, c_pe, c_par, ser;

  wire [7:0] mask  = 8'hFF >> (2'd3 - wlen);
  wire       ones  = ^(data & mask);
  wire       pbit  = par_stick ? ~par_even : (par_even ? ones : ~ones);
  wire [2:0] last  = 3'd4 + {1'b0, c_wlen};
  wire       accept = load && (st == IDLE);

  always_comb begin
    lim = CW'(TPB - 1);
    if (st == STOP && c_stop)
      lim = (c_wlen == 2'd0) ? CW'(TPB + TPB / 2 - 1) : CW'(2 * TPB - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; ser <= 1'b1; tcnt <= '0; idx <= '0; sh <= '0;
      c_wlen <= '0; c_stop <= 1'b0; c_pe <= 1'b0; c_par <= 1'b0;
    end else if (accept) begin
      st <= START; ser <= 1'b0; tcnt <= '0; idx <= '0; sh <= data;
      c_wlen <= wlen; c_stop <= stop_sel; c_pe <= par_en; c_par <= pbit;
    end else if (tick && st != IDLE) begin
      if (tcnt != lim) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        case (st)
          START: begin st <= DATA; ser <= sh[0]; end
          DATA: begin
            if (idx == last) begin
              st  <= c_pe ? PAR : STOP;
              ser <= c_pe ? c_par : 1'b1;
            end else begin
              idx <= idx + 1'b1;
              ser <= sh[1];
              sh  <= sh >> 1;
            end
          end
          PAR:  begin st <= STOP; ser <= 1'b1; end
          default: begin st <= IDLE; ser <= 1'b1; end
        endcase
      end
    end
  end

  assign busy = (st != IDLE);
  assign txd  = ser & ~brk;
endmodule

// File: rtl/uart_tx_frame_chk.sv
module uart_tx_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic load,
  input logic brk,
  input logic txd,
  input logic busy
);
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd); // R7
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd); // R2
  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> busy); // R8
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !$past(busy) && $past(rst_n)) |-> !txd); // R2
  AST_BUSY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy); // R9
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && !$past(brk)) |-> $past(txd)); // R9
endmodule

bind uart_tx_frame uart_tx_frame_chk i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
  .brk(brk), .txd(txd), .busy(busy)
);

// File: tb/test_uart_tx_frame.sv
module test_uart_tx_frame;
  logic clk = 0, rst_n = 0, tick = 0, load = 0;
  logic [7:0] data = 0;
  logic [1:0] wlen = 0;
  logic stop_sel = 0, par_en = 0, par_even = 0, par_stick = 0, brk = 0;
  logic txd, busy;
  int checks = 0, errors = 0, cyc = 0;
  logic [1:0] tcnt = 0;

  uart_tx_frame i_uart_tx_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .data(data),
    .wlen(wlen), .stop_sel(stop_sel), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .txd(txd), .busy(busy));

  always #10 clk = ~clk;
  always @(posedge clk) begin
    cyc  <= cyc + 1;
    tcnt <= tcnt + 1'b1;
    tick <= (tcnt == 2'd3);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_par(input logic [7:0] d, input logic [1:0] wl,
                                 input bit ev, input bit st);
    int n = 5 + wl;
    bit o = 0;
    for (int i = 0; i < n; i++) o ^= d[i];
    if (st) return ~ev;
    return ev ? o : ~o;
  endfunction

  function automatic int stop_ticks(input logic [1:0] wl, input bit s);
    if (!s) return 16;
    return (wl == 0) ? 24 : 32;
  endfunction

  task automatic send(input logic [7:0] d, input logic [1:0] wl, input bit s,
                      input bit pe, input bit ev, input bit st,
                      input bit mid, input bit brk_on);
    int n = 5 + wl;
    int body = 16 * (1 + n + (pe ? 1 : 0));
    int total = body + stop_ticks(wl, s);
    bit p = exp_par(d, wl, ev, st);
    int k = 0, lastk = -1;
    string sr = s ? "R4" : "R3";
    @(negedge clk);
    while (busy) @(negedge clk);
    data = d; wlen = wl; stop_sel = s; par_en = pe; par_even = ev; par_stick = st;
    brk = brk_on; load = 1;
    @(negedge clk);
    load = 0;
    chk(busy == 1, "R8", busy, 1);
    forever begin
      if (cyc > 190000) return;
      if (k != lastk) begin
        lastk = k;
        if (k % 16 == 8 && k < body) begin
          int j = k / 16;
          bit e;
          string rq;
          if (j == 0) begin e = 0; rq = "R2"; end
          else if (j <= n) begin e = d[j-1]; rq = "R1"; end
          else begin e = p; rq = st ? "R6" : "R5"; end
          if (brk_on) begin e = 0; rq = "R7"; end
          chk(txd == e, rq, txd, e);
        end
        if (k == body + 8 || k == total - 2)
          chk(txd == !brk_on, brk_on ? "R7" : sr, txd, !brk_on);
        if (k == 40 && mid) begin
          data = ~d; wlen = ~wl; stop_sel = ~s; par_en = ~pe; par_even = ~ev;
          load = 1;
        end
        if (k == 41 && mid) load = 0;
        if (k == total - 1) chk(busy == 1, "R9", busy, 1);
        if (k == total) begin
          chk(busy == 0, mid ? "R8" : sr, busy, 0);
          break;
        end
      end
      if (tick) k++;
      @(negedge clk);
    end
    if (brk_on) begin
      chk(txd == 0, "R7", txd, 0);
      brk = 0;
      #1;
      chk(txd == 1, "R7", txd, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(txd == 1 && busy == 0, "R2", {txd, busy}, 2);
    rst_n = 1;
    @(negedge clk);
    chk(txd == 1, "R2", txd, 1);
    brk = 1; #1;
    chk(txd == 0, "R7", txd, 0);
    brk = 0; #1;
    chk(txd == 1, "R7", txd, 1);
    send(8'hA5, 2'd3, 0, 0, 0, 0, 0, 0);
    send(8'h13, 2'd0, 1, 0, 0, 0, 0, 0);
    send(8'h13, 2'd0, 1, 1, 1, 0, 0, 0);
    send(8'h3C, 2'd1, 1, 1, 0, 0, 0, 0);
    send(8'h7F, 2'd2, 0, 1, 0, 1, 0, 0);
    send(8'h7F, 2'd2, 0, 1, 1, 1, 0, 0);
    send(8'hFF, 2'd3, 1, 1, 1, 0, 1, 0);
    send(8'h00, 2'd0, 0, 1, 0, 0, 1, 0);
    send(8'h5A, 2'd3, 1, 1, 0, 0, 0, 1);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] r = 8'($urandom);
      logic [5:0] c = 6'($urandom);
      send(r, c[1:0], c[2], c[3], c[4], c[5], (i % 7) == 3, 0);
    end
    finish_run();
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cyc > 195000);
    chk(0, "watchdog", cyc, 0);
    finish_run();
  end
endmodule